// File: doc/BRIEF.md
# Code Transition Calibration Monitor

This block observes the sample stream of a 14-bit converter while offset or gain trim is being adjusted. Trimming is complete when the output sits on the edge between two adjacent codes, with the least significant bit toggling evenly. One noisy sample proves nothing, so the monitor judges the result over a window of many conversions. It counts how often the stream lands on the lower code of the chosen pair, how often it lands on the upper code, and how often it misses the pair on either side.

At the end of every window the block publishes all four counts together. It also publishes a balanced flag and a hint that says whether the stream sits below the pair, above it, or centred on it. Three pair sources are available: the offset point, the gain point, or a code supplied by the user. Offset must be trimmed before gain. If a gain window completes before any offset window has ended balanced, the gain result carries an ordering error.

The block only watches the stream. The converter must keep converting for the whole observation, and the block drives no trim.

Top module: `calib_transition_monitor`

## Requirements
- R1: With `cfg_mode` = 0 (offset), the lower pair code is 0x2000 (top bit set, all other bits clear) and the upper pair code is 0x2001.
- R2: With `cfg_mode` = 1 (gain), the lower pair code is 0x0000 and the upper pair code is 0x0001.
- R3: With `cfg_mode` = 2 or 3 (user), the lower pair code is `cfg_user_code` with bit 0 forced to 0, and the upper pair code is the same value with bit 0 forced to 1.
- R4: A window holds 2^L accepted samples, where L is `cfg_win_log2` clamped to the range 4..16. Only cycles with `smp_valid` = 1 are counted, and all other cycles have no effect on the counts.
- R5: `res_done` is high for exactly one cycle, the cycle that follows the clock edge accepting the last sample of a window. All result outputs change only at that edge and hold their value at all other times. The next window's counts start from zero.
- R6: `res_balanced` is 1 when two conditions both hold: |lower count − upper count| ≤ `cfg_tol`, and lower count + upper count ≥ half the window length.
- R7: A sample below the lower pair code increments the below count. A sample above the upper pair code increments the above count. The four published counts always add up to the window length.
- R8: `res_dir` uses 0 = centred, 1 = low, 2 = high. It is 0 when the window is balanced. Otherwise it compares (below + lower) with (above + upper): 1 if the first is larger, 2 if the second is larger, and 0 if they are equal.
- R9: `res_order_err` is 1 for a gain window when no offset window since reset has ended balanced. It is 0 for every other window.
- R10: Mode, user code, window length and tolerance are captured with the first sample of a window. Changes made later in that window have no effect on it.
- R11: During and after reset, all result outputs are 0 and `res_done` is 0 until the first window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, one conversion per high cycle |
| smp_code | input | 14 | Converter output code |
| cfg_mode | input | 2 | Pair source: 0 offset, 1 gain, 2/3 user |
| cfg_user_code | input | 14 | Code used in user mode |
| cfg_win_log2 | input | 5 | Base-2 logarithm of the window length |
| cfg_tol | input | 17 | Allowed difference between the two pair counts |
| res_done | output | 1 | One-cycle pulse when a window result is published |
| res_cnt_even | output | 17 | Count of samples on the lower pair code |
| res_cnt_odd | output | 17 | Count of samples on the upper pair code |
| res_cnt_below | output | 17 | Count of samples below the pair |
| res_cnt_above | output | 17 | Count of samples above the pair |
| res_balanced | output | 1 | Window met the balance rule |
| res_dir | output | 2 | Direction hint |
| res_order_err | output | 1 | Gain window seen before a balanced offset window |

## Verification
Some properties are checked on every cycle. These are: the done pulse never lasts two cycles, results move only when done rises, the four counts fill exactly the window that just closed, a balanced result always reports a centred hint and pair counts of at least half the window, no sample falls into two classes, and the sample index stays inside the window. Other behaviour can only be shown by the bench's scenarios. That includes the specific pair codes each mode selects, the clamping of the window length, the tolerance and half-window boundaries, the low, high and tie outcomes of the hint, the ordering error disappearing once offset has balanced, and configuration changes in mid-window being ignored.

// File: rtl/calmon_pkg.sv
package calmon_pkg;

    typedef enum logic [1:0] {
        CM_OFFSET   = 2'd0,
        CM_GAIN     = 2'd1,
        CM_USER     = 2'd2,
        CM_USER_ALT = 2'd3
    } cal_mode_e;

    typedef enum logic [1:0] {
        HINT_CENTRED = 2'd0,
        HINT_LOW     = 2'd1,
        HINT_HIGH    = 2'd2
    } hint_e;

    typedef struct packed {
        logic hit_even;
        logic hit_odd;
        logic below;
        logic above;
    } smp_class_t;

endpackage

// File: rtl/calmon_pair_sel.sv
module calmon_pair_sel #(
    parameter int DW = 14
) (
    input  logic [1:0]    mode,
    input  logic [DW-1:0] user_code,
    output logic [DW-1:0] even_code,
    output logic [DW-1:0] odd_code
);
    import calmon_pkg::*;

    if (DW < 2) begin : g_width_check
        $error("calmon_pair_sel needs at least two data bits");
    end

    logic [DW-1:0] base;

    always_comb begin
        case (mode)
            CM_OFFSET: base = {1'b1, {(DW-1){1'b0}}};
            CM_GAIN:   base = '0;
            default:   base = user_code;
        endcase
        even_code = {base[DW-1:1], 1'b0};
        odd_code  = {base[DW-1:1], 1'b1};
    end

endmodule

// File: rtl/calmon_classify.sv
module calmon_classify #(
    parameter int DW = 14
) (
    input  logic                   valid,
    input  logic [DW-1:0]          code,
    input  logic [DW-1:0]          even_code,
    input  logic [DW-1:0]          odd_code,
    output calmon_pkg::smp_class_t cls
);
    always_comb begin
        cls.hit_even = valid && (code == even_code);
        cls.hit_odd  = valid && (code == odd_code);
        cls.below    = valid && (code < even_code);
        cls.above    = valid && (code > odd_code);
    end

    // R7: every sample lands in at most one class
    always_comb begin
        a_r7_class_exclusive: assert ($onehot0({cls.hit_even, cls.hit_odd, cls.below, cls.above}));
    end

endmodule

// File: rtl/calmon_window.sv
module calmon_window #(
    parameter int DW       = 14,
    parameter int MIN_LOG2 = 4,
    parameter int MAX_LOG2 = 16,
    parameter int CW       = MAX_LOG2 + 1,
    parameter int LW       = $clog2(MAX_LOG2 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [1:0]    cfg_mode,
    input  logic [DW-1:0] cfg_user_code,
    input  logic [LW-1:0] cfg_win_log2,
    input  logic [CW-1:0] cfg_tol,
    output logic [1:0]    eff_mode,
    output logic [DW-1:0] eff_user_code,
    output logic [LW-1:0] eff_log2,
    output logic [CW-1:0] eff_tol,
    output logic [LW-1:0] win_log2_q,
    output logic          win_last
);
    typedef struct packed {
        logic [CW-1:0] idx;
        logic [1:0]    mode;
        logic [DW-1:0] user;
        logic [CW-1:0] tol;
        logic [LW-1:0] log2;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [LW-1:0] log2_clamped;
    logic [CW-1:0] win_len;
    logic          at_start;

    always_comb begin
        if (cfg_win_log2 < LW'(MIN_LOG2))      log2_clamped = LW'(MIN_LOG2);
        else if (cfg_win_log2 > LW'(MAX_LOG2)) log2_clamped = LW'(MAX_LOG2);
        else                                   log2_clamped = cfg_win_log2;

        at_start      = (st_q.idx == '0);
        eff_mode      = at_start ? cfg_mode      : st_q.mode;
        eff_user_code = at_start ? cfg_user_code : st_q.user;
        eff_log2      = at_start ? log2_clamped  : st_q.log2;
        eff_tol       = at_start ? cfg_tol       : st_q.tol;

        win_len  = CW'(1) << eff_log2;
        win_last = smp_valid && (st_q.idx == win_len - CW'(1));

        st_d = st_q;
        if (smp_valid) begin
            if (at_start) begin
                st_d.mode = cfg_mode;
                st_d.user = cfg_user_code;
                st_d.log2 = log2_clamped;
                st_d.tol  = cfg_tol;
            end
            st_d.idx = win_last ? '0 : st_q.idx + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.log2 <= LW'(MIN_LOG2);
        end else begin
            st_q <= st_d;
        end
    end

    assign win_log2_q = st_q.log2;

    // R4: the running index never leaves the captured window
    a_r4_idx_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx != '0) |-> (st_q.idx < (CW'(1) << st_q.log2)));

endmodule

// File: rtl/calmon_judge.sv
module calmon_judge #(
    parameter int CW = 17,
    parameter int LW = 5
) (
    input  logic [CW-1:0] n_even,
    input  logic [CW-1:0] n_odd,
    input  logic [CW-1:0] n_below,
    input  logic [CW-1:0] n_above,
    input  logic [LW-1:0] log2,
    input  logic [CW-1:0] tol,
    output logic          balanced,
    output logic [1:0]    hint
);
    import calmon_pkg::*;

    logic [CW:0]   pair_sum;
    logic [CW:0]   half_win;
    logic [CW:0]   low_side;
    logic [CW:0]   high_side;
    logic [CW-1:0] spread;

    always_comb begin
        pair_sum  = {1'b0, n_even} + {1'b0, n_odd};
        half_win  = ((CW+1)'(1) << log2) >> 1;
        spread    = (n_even >= n_odd) ? (n_even - n_odd) : (n_odd - n_even);
        balanced  = (spread <= tol) && (pair_sum >= half_win);
        low_side  = {1'b0, n_even} + {1'b0, n_below};
        high_side = {1'b0, n_odd}  + {1'b0, n_above};
        if (balanced)                  hint = HINT_CENTRED;
        else if (low_side > high_side) hint = HINT_LOW;
        else if (high_side > low_side) hint = HINT_HIGH;
        else                           hint = HINT_CENTRED;
    end

endmodule

// File: rtl/calib_transition_monitor.sv
module calib_transition_monitor #(
    parameter int  DW       = 14,
    parameter int  MIN_LOG2 = 4,
    parameter int  MAX_LOG2 = 16,
    localparam int CW       = MAX_LOG2 + 1,
    localparam int LW       = $clog2(MAX_LOG2 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_code,
    input  logic [1:0]    cfg_mode,
    input  logic [DW-1:0] cfg_user_code,
    input  logic [LW-1:0] cfg_win_log2,
    input  logic [CW-1:0] cfg_tol,
    output logic          res_done,
    output logic [CW-1:0] res_cnt_even,
    output logic [CW-1:0] res_cnt_odd,
    output logic [CW-1:0] res_cnt_below,
    output logic [CW-1:0] res_cnt_above,
    output logic          res_balanced,
    output logic [1:0]    res_dir,
    output logic          res_order_err
);
    import calmon_pkg::*;

    typedef struct packed {
        logic [CW-1:0] acc_even;
        logic [CW-1:0] acc_odd;
        logic [CW-1:0] acc_below;
        logic [CW-1:0] acc_above;
        logic [CW-1:0] r_even;
        logic [CW-1:0] r_odd;
        logic [CW-1:0] r_below;
        logic [CW-1:0] r_above;
        logic          r_bal;
        logic [1:0]    r_hint;
        logic          r_ord;
        logic [1:0]    r_mode;
        logic          done;
        logic          off_ok;
    } mon_st_t;

    mon_st_t s_d, s_q;

    logic [1:0]    eff_mode;
    logic [DW-1:0] eff_user_code;
    logic [LW-1:0] eff_log2;
    logic [CW-1:0] eff_tol;
    logic [LW-1:0] win_log2_q;
    logic          win_last;
    logic [DW-1:0] even_code;
    logic [DW-1:0] odd_code;
    smp_class_t    cls;
    logic [CW-1:0] fin_even, fin_odd, fin_below, fin_above;
    logic          fin_bal;
    logic [1:0]    fin_hint;

    calmon_window #(
        .DW(DW), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .CW(CW), .LW(LW)
    ) u_window (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid     (smp_valid),
        .cfg_mode      (cfg_mode),
        .cfg_user_code (cfg_user_code),
        .cfg_win_log2  (cfg_win_log2),
        .cfg_tol       (cfg_tol),
        .eff_mode      (eff_mode),
        .eff_user_code (eff_user_code),
        .eff_log2      (eff_log2),
        .eff_tol       (eff_tol),
        .win_log2_q    (win_log2_q),
        .win_last      (win_last)
    );

    calmon_pair_sel #(.DW(DW)) u_pair (
        .mode      (eff_mode),
        .user_code (eff_user_code),
        .even_code (even_code),
        .odd_code  (odd_code)
    );

    calmon_classify #(.DW(DW)) u_class (
        .valid     (smp_valid),
        .code      (smp_code),
        .even_code (even_code),
        .odd_code  (odd_code),
        .cls       (cls)
    );

    calmon_judge #(.CW(CW), .LW(LW)) u_judge (
        .n_even   (fin_even),
        .n_odd    (fin_odd),
        .n_below  (fin_below),
        .n_above  (fin_above),
        .log2     (eff_log2),
        .tol      (eff_tol),
        .balanced (fin_bal),
        .hint     (fin_hint)
    );

    always_comb begin
        fin_even  = s_q.acc_even  + CW'(cls.hit_even);
        fin_odd   = s_q.acc_odd   + CW'(cls.hit_odd);
        fin_below = s_q.acc_below + CW'(cls.below);
        fin_above = s_q.acc_above + CW'(cls.above);

        s_d      = s_q;
        s_d.done = 1'b0;
        if (win_last) begin
            s_d.acc_even  = '0;
            s_d.acc_odd   = '0;
            s_d.acc_below = '0;
            s_d.acc_above = '0;
            s_d.r_even    = fin_even;
            s_d.r_odd     = fin_odd;
            s_d.r_below   = fin_below;
            s_d.r_above   = fin_above;
            s_d.r_bal     = fin_bal;
            s_d.r_hint    = fin_hint;
            s_d.r_ord     = (eff_mode == CM_GAIN) && !s_q.off_ok;
            s_d.r_mode    = eff_mode;
            s_d.done      = 1'b1;
            if ((eff_mode == CM_OFFSET) && fin_bal) s_d.off_ok = 1'b1;
        end else begin
            s_d.acc_even  = fin_even;
            s_d.acc_odd   = fin_odd;
            s_d.acc_below = fin_below;
            s_d.acc_above = fin_above;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_done      = s_q.done;
    assign res_cnt_even  = s_q.r_even;
    assign res_cnt_odd   = s_q.r_odd;
    assign res_cnt_below = s_q.r_below;
    assign res_cnt_above = s_q.r_above;
    assign res_balanced  = s_q.r_bal;
    assign res_dir       = s_q.r_hint;
    assign res_order_err = s_q.r_ord;

    // R5: the publish strobe is a single-cycle pulse
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R5: results only move together with the strobe
    a_r5_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.done |-> ($stable(s_q.r_even) && $stable(s_q.r_odd) &&
                       $stable(s_q.r_below) && $stable(s_q.r_above) &&
                       $stable(s_q.r_bal) && $stable(s_q.r_hint) && $stable(s_q.r_ord)));

    // R7: the four published counts fill the window that just closed
    a_r7_counts_fill_window: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> ((CW+2)'(s_q.r_even) + (CW+2)'(s_q.r_odd) +
                      (CW+2)'(s_q.r_below) + (CW+2)'(s_q.r_above)
                      == ((CW+2)'(1) << win_log2_q)));

    // R8: a balanced window always reports a centred hint
    a_r8_balanced_centred: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && s_q.r_bal) |-> (s_q.r_hint == HINT_CENTRED));

    // R6: a balanced window holds at least half its samples on the pair
    a_r6_balanced_half: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && s_q.r_bal) |-> (((CW+2)'(s_q.r_even) + (CW+2)'(s_q.r_odd)) * 2
                                     >= ((CW+2)'(1) << win_log2_q)));

    // R9: an ordering error only ever belongs to a gain window
    a_r9_order_gain_only: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.r_ord |-> (s_q.r_mode == CM_GAIN));

endmodule

// File: tb/calib_transition_monitor_tb.sv
module calib_transition_monitor_tb;

    localparam int DW = 14;
    localparam int CW = 17;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_code = '0;
    logic [1:0]    cfg_mode = '0;
    logic [DW-1:0] cfg_user_code = '0;
    logic [LW-1:0] cfg_win_log2 = 5'd4;
    logic [CW-1:0] cfg_tol = '0;
    logic          res_done;
    logic [CW-1:0] res_cnt_even, res_cnt_odd, res_cnt_below, res_cnt_above;
    logic          res_balanced;
    logic [1:0]    res_dir;
    logic          res_order_err;

    always #4 clk = ~clk;

    calib_transition_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .cfg_mode(cfg_mode), .cfg_user_code(cfg_user_code),
        .cfg_win_log2(cfg_win_log2), .cfg_tol(cfg_tol),
        .res_done(res_done), .res_cnt_even(res_cnt_even), .res_cnt_odd(res_cnt_odd),
        .res_cnt_below(res_cnt_below), .res_cnt_above(res_cnt_above),
        .res_balanced(res_balanced), .res_dir(res_dir), .res_order_err(res_order_err)
    );

    typedef struct {
        string tag;
        int    ne, no, nb, na;
        int    bal, dir, ord;
    } exp_t;

    exp_t scb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   n_windows = 0;
    int   n_done = 0;
    int   hold_bad = 0;
    bit   off_ok_model = 1'b0;
    bit   prev_done = 1'b0;
    logic [CW-1:0] last_e, last_o, last_b, last_a;
    logic last_bal, last_ord;
    logic [1:0] last_dir;
    bit   finished = 1'b0;

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Driver: computes the expected result from the requirements, queues it, then drives the window
    task automatic run_win(string tag, int mode, int user, int wl, int tol,
                           int ne, int no, int nb, int na, bit gaps, bit disturb);
        exp_t e;
        int lo_code, hi_code, n, l, lo_side, hi_side, diff, idx;
        if (mode == 0)      begin lo_code = 'h2000; hi_code = 'h2001; end
        else if (mode == 1) begin lo_code = 0;      hi_code = 1;      end
        else                begin lo_code = user & ~1; hi_code = user | 1; end
        l = (wl < 4) ? 4 : (wl > 16) ? 16 : wl;
        n = 1 << l;
        if (ne + no + nb + na != n) $display("bench setup mismatch in %s", tag);
        diff = (ne > no) ? ne - no : no - ne;
        e.tag = tag; e.ne = ne; e.no = no; e.nb = nb; e.na = na;
        e.bal = (diff <= tol && 2 * (ne + no) >= n) ? 1 : 0;
        lo_side = nb + ne;
        hi_side = na + no;
        e.dir = e.bal ? 0 : (lo_side > hi_side) ? 1 : (hi_side > lo_side) ? 2 : 0;
        e.ord = (mode == 1 && !off_ok_model) ? 1 : 0;
        if (mode == 0 && e.bal) off_ok_model = 1'b1;
        scb.push_back(e);
        n_windows++;
        idx = 0;
        for (int i = 0; i < n; i++) begin
            int code;
            if (i < nb)                code = lo_code - 1 - (i % 3);
            else if (i < nb + ne)      code = lo_code;
            else if (i < nb + ne + no) code = hi_code;
            else                       code = hi_code + 1 + (i % 3);
            if (gaps && (i % 3 == 1)) begin
                @(posedge clk); #1;
                smp_valid = 1'b0;
                smp_code  = DW'(lo_code);
            end
            @(posedge clk); #1;
            if (i == 0) begin
                cfg_mode      = 2'(mode);
                cfg_user_code = DW'(user);
                cfg_win_log2  = LW'(wl);
                cfg_tol       = CW'(tol);
            end else if (disturb) begin
                cfg_mode      = 2'd1;
                cfg_user_code = '0;
                cfg_win_log2  = 5'd5;
                cfg_tol       = '0;
            end
            smp_valid = 1'b1;
            smp_code  = DW'(code);
            idx++;
        end
    endtask

    // Monitor: pops expected items as the design publishes results
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_done) begin
                n_done++;
                if (prev_done) chk("R5", "done wider than one cycle", 1, 0);
                if (scb.size() == 0) begin
                    chk("R5", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = scb.pop_front();
                    chk(e.tag, "lower pair count", res_cnt_even, e.ne);
                    chk(e.tag, "upper pair count", res_cnt_odd, e.no);
                    chk("R7",  "below count", res_cnt_below, e.nb);
                    chk("R7",  "above count", res_cnt_above, e.na);
                    chk("R6",  "balanced", res_balanced, e.bal);
                    chk("R8",  "direction hint", res_dir, e.dir);
                    chk("R9",  "ordering error", res_order_err, e.ord);
                end
                last_e = res_cnt_even; last_o = res_cnt_odd;
                last_b = res_cnt_below; last_a = res_cnt_above;
                last_bal = res_balanced; last_dir = res_dir; last_ord = res_order_err;
            end else begin
                if (res_cnt_even !== last_e || res_cnt_odd !== last_o ||
                    res_cnt_below !== last_b || res_cnt_above !== last_a ||
                    res_balanced !== last_bal || res_dir !== last_dir ||
                    res_order_err !== last_ord)
                    hold_bad++;
            end
            prev_done = res_done;
        end
    end

    initial begin
        #(8 * 200000);
        chk("WATCHDOG", "run did not finish", 1, 0);
        finish_run();
    end

    initial begin
        last_e = '0; last_o = '0; last_b = '0; last_a = '0;
        last_bal = 1'b0; last_dir = '0; last_ord = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: outputs during reset
        chk("R11", "done in reset", res_done, 0);
        chk("R11", "counts in reset", res_cnt_even | res_cnt_odd | res_cnt_below | res_cnt_above, 0);
        chk("R11", "flags in reset", {res_balanced, res_dir, res_order_err}, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11", "done after reset", res_done, 0);
        chk("R11", "hint after reset", res_dir, 0);

        run_win("R2",  1, 0,      4, 2,  8, 8, 0, 0, 0, 0);
        run_win("R1",  0, 0,      4, 1,  5, 9, 1, 1, 0, 0);
        run_win("R9",  1, 0,      4, 0,  8, 8, 0, 0, 0, 0);
        run_win("R1",  0, 0,      5, 2,  9, 8, 10, 5, 0, 0);
        run_win("R2",  1, 0,      4, 3,  4, 3, 0, 9, 0, 0);
        run_win("R3",  2, 'h1235, 2, 0,  10, 2, 3, 1, 0, 0);
        run_win("R10", 3, 'h0ABC, 4, 1,  8, 7, 1, 0, 1, 1);
        run_win("R6",  0, 0,      6, 4,  30, 26, 4, 4, 0, 0);
        run_win("R8",  0, 0,      4, 3,  8, 4, 0, 4, 0, 0);
        run_win("R6",  1, 0,      4, 0,  4, 4, 0, 8, 0, 0);
        run_win("R4",  2, 'h3FFE, 20, 0, 32768, 32768, 0, 0, 0, 0);

        @(posedge clk); #1;
        smp_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5", "results held between pulses", hold_bad, 0);
        chk("R5", "every window published", n_done, n_windows);
        chk("R4", "no pending windows", scb.size(), 0);
        finish_run();
    end

endmodule